// File: doc/BRIEF.md
# Address-Encoded Atomic Register Window

This block is the host-facing byte window into a network adapter's control registers. Each access is one byte. The address carries the register index, the operation and the area together. The host can therefore overwrite a register, clear bits with an AND mask, set bits with an OR mask, or read a register, all in one bus access and with no read-modify-write sequence in software. The window holds these parts:

- plain control bytes;
- a read-only RAM-size field;
- a relocation byte that drives the shared-RAM base address bits;
- a host interrupt status register with a global enable;
- a prescaled countdown timer that raises a timer interrupt;
- two read-only identification areas.

One interrupt line goes to the host. It is high while the enable bit is set and any pending bit is set. Software acknowledges an interrupt by ANDing zeros into the pending positions. Any access the window cannot honour sets an access-error pending bit. This covers modifying a read-only location, touching the reserved area and naming a control index that does not exist.

Top module: `rmw_ctrl_window`

## Requirements
- R1: `acc_addr[4:0]` is the register index, `acc_addr[6:5]` the operation (00 write, 01 AND, 10 OR, 11 read) and `acc_addr[8:7]` the area (00 control, 01 reserved, 10 ID area A, 11 ID area B); a write op replaces a writable control byte with `acc_wdata`.
- R2: An AND op stores `old & acc_wdata` and an OR op stores `old | acc_wdata` into the addressed writable control byte, in one access.
- R3: A read op puts the addressed byte on `rd_data` with `rd_valid` high in the cycle after the access; `rd_valid` is low after every non-read access.
- R4: Control index 0x08 is the interrupt status byte: bit 6 enable, bit 4 timer pending, bit 2 access-error pending, other bits read 0. `irq` = bit6 AND (bit4 OR bit2); an AND op clears pending bits.
- R5: Index 0x0C bit 7 is the timer run bit and index 0x0E is the timer reload/value byte. While running, the count drops once every `TICK_DIV` cycles. A tick with a count of 1 or 0 reloads the count and sets status bit 4. While run is 0 the count holds and no timer interrupt appears.
- R6: Index 0x01 is read-only: bits 3:2 hold `RAM_SIZE_CODE` (00 = 8 KiB, 01 = 16 KiB, 10 = 32 KiB, 11 = 64 KiB) and the other bits read 0; a write/AND/OR to it leaves it unchanged and sets status bit 2.
- R7: Index 0x00 bits 7:1 are writable and drive `ram_base[6:0]` (shared-RAM address bits 19:13); bit 0 always reads 0.
- R8: ID area A byte i (index i < 6) returns `ADDR_ID[8*i+7:8*i]`, higher indices return 0x00; a write/AND/OR there changes nothing and sets status bit 2.
- R9: ID area B byte i returns (i odd ? 0x55 : 0xAA) XOR i.
- R10: Any access to the reserved area, or to a control index outside {0x00-0x08, 0x0C, 0x0E, 0x18}, sets status bit 2, and a read of either returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Byte access present this cycle |
| acc_addr | input | 9 | Area, operation and index of the access |
| acc_wdata | input | 8 | Data byte for write, AND or OR |
| rd_valid | output | 1 | Read data valid (one cycle after a read op) |
| rd_data | output | 8 | Read data byte |
| irq | output | 1 | Host interrupt request |
| ram_base | output | 7 | Shared-RAM base address bits 19:13 |

## Verification
The assertions check four things on every cycle:
- the read-only size field always reads back with its fixed code;
- a reserved-area read always returns zero;
- `rd_valid` only ever follows a read op;
- each timer expiry and each illegal access lands in its pending bit on the next edge, and a stopped timer never changes its count.

The bench scenarios are needed for the rest. They show the AND and OR results, that the reload period matches the prescaler, and that the enable gate holds `irq` low. They also show that modify attempts on read-only locations leave the contents intact, which is visible only by reading them back.

// File: rtl/rmw_win_pkg.sv
// Package: shared types and pure functions for the register window.
// Assumes a 9-bit byte address split into area[8:7], op[6:5], idx[4:0].
package rmw_win_pkg;

    typedef enum logic [1:0] {
        OP_WR  = 2'b00,
        OP_AND = 2'b01,
        OP_OR  = 2'b10,
        OP_RD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        AR_CTRL = 2'b00,
        AR_RSV  = 2'b01,
        AR_IDA  = 2'b10,
        AR_IDB  = 2'b11
    } area_e;

    localparam int IDX_W       = 5;
    localparam int AREA_DEPTH  = 1 << IDX_W;
    localparam int NSLOT       = 9;

    localparam logic [IDX_W-1:0] IX_RELOC = 5'h00;
    localparam logic [IDX_W-1:0] IX_SIZE  = 5'h01;
    localparam logic [IDX_W-1:0] IX_STAT  = 5'h08;
    localparam logic [IDX_W-1:0] IX_TCTL  = 5'h0C;
    localparam logic [IDX_W-1:0] IX_TVAL  = 5'h0E;
    localparam logic [IDX_W-1:0] IX_PAGE  = 5'h18;

    // Combine an old byte with the data byte according to the operation.
    function automatic logic [7:0] apply_op(op_e op, logic [7:0] old, logic [7:0] d);
        case (op)
            OP_WR:   return d;
            OP_AND:  return old & d;
            OP_OR:   return old | d;
            default: return old;
        endcase
    endfunction

    // True when the control index names an existing register.
    function automatic logic idx_exists(logic [IDX_W-1:0] ix);
        return (ix <= 5'h08) || (ix == IX_TCTL) || (ix == IX_TVAL) || (ix == IX_PAGE);
    endfunction

    // Storage slot of a plain byte register, -1 if the index is not plain.
    function automatic int slot_of(logic [IDX_W-1:0] ix);
        if (ix == IX_RELOC)                return 0;
        if (ix >= 5'h02 && ix <= 5'h07)    return int'(ix) - 1;
        if (ix == IX_TCTL)                 return 7;
        if (ix == IX_PAGE)                 return 8;
        return -1;
    endfunction

    // Fixed test pattern byte of identification area B.
    function automatic logic [7:0] idb_byte(logic [IDX_W-1:0] ix);
        return (ix[0] ? 8'h55 : 8'hAA) ^ {3'b000, ix};
    endfunction

endpackage

// File: rtl/rmw_decode.sv
// Module: splits an access address into its fields and classifies it.
// Assumes: purely combinational; acc_valid qualifies every output strobe.
module rmw_decode
    import rmw_win_pkg::*;
(
    input  logic             acc_valid,
    input  logic [8:0]       acc_addr,
    output op_e              op,
    output area_e            area,
    output logic [IDX_W-1:0] idx,
    output logic             rd_strobe,
    output logic             mod_strobe,
    output logic             err_strobe,
    output logic             ctrl_hit
);

    logic is_modify;
    logic read_only;

    // Field extraction.
    always_comb begin
        idx  = acc_addr[4:0];
        op   = op_e'(acc_addr[6:5]);
        area = area_e'(acc_addr[8:7]);
    end

    // Classification of the access.
    always_comb begin
        is_modify  = (op != OP_RD);
        ctrl_hit   = (area == AR_CTRL) && idx_exists(idx);
        read_only  = (area == AR_IDA) || (area == AR_IDB) ||
                     ((area == AR_CTRL) && (idx == IX_SIZE));
        rd_strobe  = acc_valid && !is_modify;
        mod_strobe = acc_valid && is_modify && ctrl_hit && !read_only;
        err_strobe = acc_valid && ((area == AR_RSV) ||
                                   ((area == AR_CTRL) && !idx_exists(idx)) ||
                                   (is_modify && read_only));
    end

endmodule

// File: rtl/rmw_timer.sv
// Module: prescaled countdown timer with reload register.
// Assumes: load has priority over a tick in the same cycle; an expiry
// reloads the count from the last loaded value.
module rmw_timer
    import rmw_win_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int TMR_W    = 8
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  op_e              op,
    input  logic [7:0]       wdata,
    output logic [TMR_W-1:0] cnt,
    output logic             expire
);

    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PRE_W-1:0] pre_q;
    logic [TMR_W-1:0] rel_q;
    logic [TMR_W-1:0] load_val;
    logic             tick;

    // Tick and expiry qualification.
    always_comb begin
        tick     = run && (pre_q == PRE_W'(TICK_DIV - 1));
        expire   = tick && !load && (cnt <= TMR_W'(1));
        load_val = TMR_W'(apply_op(op, 8'(rel_q), wdata));
    end

    // Prescaler counts only while the timer runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) pre_q <= '0;
        else                        pre_q <= pre_q + PRE_W'(1);
    end

    // Reload register and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_q <= '0;
            cnt   <= '0;
        end else if (load) begin
            rel_q <= load_val;
            cnt   <= load_val;
        end else if (tick) begin
            cnt <= (cnt <= TMR_W'(1)) ? rel_q : cnt - TMR_W'(1);
        end
    end

    // R5
    // hold_when_stopped_chk
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));

endmodule

// File: rtl/rmw_id_rom.sv
// Module: the two read-only identification areas.
// Assumes: area A holds ID_BYTES bytes of ADDR_ID, least significant first.
module rmw_id_rom
    import rmw_win_pkg::*;
#(
    parameter int          ID_BYTES = 6,
    parameter logic [47:0] ADDR_ID  = 48'h10_00_5A_C3_19_7E
)(
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       ida_byte,
    output logic [7:0]       idb_out
);

    logic [7:0] ida_tab [AREA_DEPTH];

    // Build area A: parameter bytes, then zeros.
    for (genvar i = 0; i < AREA_DEPTH; i++) begin : g_ida
        if (i < ID_BYTES) begin : g_val
            assign ida_tab[i] = ADDR_ID[8*i +: 8];
        end else begin : g_zero
            assign ida_tab[i] = 8'h00;
        end
    end

    // Select the addressed byte of each area.
    always_comb begin
        ida_byte = ida_tab[idx];
        idb_out  = idb_byte(idx);
    end

endmodule

// File: rtl/rmw_regfile.sv
// Module: plain control bytes, read-only size byte and interrupt status.
// Assumes: mod_strobe is only asserted for writable existing indices;
// hardware set events win over a host clear in the same cycle.
module rmw_regfile
    import rmw_win_pkg::*;
#(
    parameter int         TMR_W         = 8,
    parameter logic [1:0] RAM_SIZE_CODE = 2'b10
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_strobe,
    input  logic             err_strobe,
    input  op_e              op,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    input  logic             expire,
    input  logic [TMR_W-1:0] tmr_cnt,
    output logic [7:0]       ctrl_byte,
    output logic             tmr_run,
    output logic             tmr_load,
    output logic             irq_en,
    output logic             pend_tmr,
    output logic             pend_err,
    output logic [6:0]       ram_base
);

    logic [7:0] slot_q  [NSLOT];
    logic [7:0] slot_nx [NSLOT];
    logic [7:0] stat_cur;
    logic [7:0] stat_new;
    logic       stat_hit;

    // Next value of each plain byte register.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [7:0] MASK = (s == 0) ? 8'hFE : 8'hFF;
        assign slot_nx[s] = (mod_strobe && slot_of(idx) == s) ?
                            (apply_op(op, slot_q[s], wdata) & MASK) : slot_q[s];
    end

    // Register update of the plain bytes.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NSLOT; s++) begin
            slot_q[s] <= rst_n ? slot_nx[s] : 8'h00;
        end
    end

    // Host-side view and modification of the status byte.
    always_comb begin
        stat_cur = {1'b0, irq_en, 1'b0, pend_tmr, 1'b0, pend_err, 2'b00};
        stat_hit = mod_strobe && (idx == IX_STAT);
        stat_new = stat_hit ? apply_op(op, stat_cur, wdata) : stat_cur;
    end

    // Status byte: host op first, hardware set events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en   <= 1'b0;
            pend_tmr <= 1'b0;
            pend_err <= 1'b0;
        end else begin
            irq_en   <= stat_new[6];
            pend_tmr <= stat_new[4] | expire;
            pend_err <= stat_new[2] | err_strobe;
        end
    end

    // Derived controls for the timer and the RAM base output.
    always_comb begin
        tmr_run  = slot_q[7][7];
        tmr_load = mod_strobe && (idx == IX_TVAL);
        ram_base = slot_q[0][7:1];
    end

    // Read view of the addressed control index.
    always_comb begin
        if (slot_of(idx) >= 0)     ctrl_byte = slot_q[slot_of(idx)];
        else if (idx == IX_SIZE)   ctrl_byte = {4'b0000, RAM_SIZE_CODE, 2'b00};
        else if (idx == IX_STAT)   ctrl_byte = stat_cur;
        else if (idx == IX_TVAL)   ctrl_byte = 8'(tmr_cnt);
        else                       ctrl_byte = 8'h00;
    end

    // R10
    // err_flag_chk
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |=> pend_err);

    // R5
    // tmr_flag_chk
    tmr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend_tmr);

endmodule

// File: rtl/rmw_ctrl_window.sv
// Module: top of the address-encoded atomic register window.
// Assumes: one byte access per cycle; read data is registered and appears
// with rd_valid one cycle after the read access.
module rmw_ctrl_window
    import rmw_win_pkg::*;
#(
    parameter int          TICK_DIV      = 4,
    parameter int          TMR_W         = 8,
    parameter logic [1:0]  RAM_SIZE_CODE = 2'b10,
    parameter int          ID_BYTES      = 6,
    parameter logic [47:0] ADDR_ID       = 48'h10_00_5A_C3_19_7E
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_valid,
    input  logic [8:0] acc_addr,
    input  logic [7:0] acc_wdata,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       irq,
    output logic [6:0] ram_base
);

    op_e              op;
    area_e            area;
    logic [IDX_W-1:0] idx;
    logic             rd_strobe, mod_strobe, err_strobe, ctrl_hit;
    logic [7:0]       ctrl_byte, ida_byte, idb_out, rd_sel;
    logic             tmr_run, tmr_load, expire;
    logic             irq_en, pend_tmr, pend_err;
    logic [TMR_W-1:0] tmr_cnt;

    rmw_decode u_dec (
        .acc_valid (acc_valid), .acc_addr (acc_addr),
        .op (op), .area (area), .idx (idx),
        .rd_strobe (rd_strobe), .mod_strobe (mod_strobe),
        .err_strobe (err_strobe), .ctrl_hit (ctrl_hit)
    );

    rmw_regfile #(.TMR_W (TMR_W), .RAM_SIZE_CODE (RAM_SIZE_CODE)) u_regs (
        .clk (clk), .rst_n (rst_n),
        .mod_strobe (mod_strobe), .err_strobe (err_strobe),
        .op (op), .idx (idx), .wdata (acc_wdata),
        .expire (expire), .tmr_cnt (tmr_cnt),
        .ctrl_byte (ctrl_byte), .tmr_run (tmr_run), .tmr_load (tmr_load),
        .irq_en (irq_en), .pend_tmr (pend_tmr), .pend_err (pend_err),
        .ram_base (ram_base)
    );

    rmw_timer #(.TICK_DIV (TICK_DIV), .TMR_W (TMR_W)) u_tmr (
        .clk (clk), .rst_n (rst_n),
        .run (tmr_run), .load (tmr_load), .op (op), .wdata (acc_wdata),
        .cnt (tmr_cnt), .expire (expire)
    );

    rmw_id_rom #(.ID_BYTES (ID_BYTES), .ADDR_ID (ADDR_ID)) u_id (
        .idx (idx), .ida_byte (ida_byte), .idb_out (idb_out)
    );

    // Area multiplexer for read data.
    always_comb begin
        case (area)
            AR_CTRL: rd_sel = ctrl_hit ? ctrl_byte : 8'h00;
            AR_IDA:  rd_sel = ida_byte;
            AR_IDB:  rd_sel = idb_out;
            default: rd_sel = 8'h00;
        endcase
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            rd_valid <= rd_strobe;
            rd_data  <= rd_strobe ? rd_sel : 8'h00;
        end
    end

    // Enable-gated interrupt request.
    always_comb irq = irq_en && (pend_tmr || pend_err);

    // R3
    // rdv_source_chk
    rdv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && acc_addr[6:5] == 2'b11));

    // R10
    // rsv_zero_chk
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[8:5] == 4'b0111) |=> (rd_valid && rd_data == 8'h00));

    // R6
    // size_ro_chk
    size_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr == 9'h061) |=> (rd_data == {4'b0000, RAM_SIZE_CODE, 2'b00}));

endmodule

// File: tb/sim_rmw_ctrl_window.sv
// Scoreboard bench: driver tasks queue expected read bytes, a monitor
// pops and compares them as rd_valid returns.
module sim_rmw_ctrl_window;

    localparam int          DIV   = 4;
    localparam logic [47:0] ID_A  = 48'h10_00_5A_C3_19_7E;
    localparam logic [1:0]  SZ    = 2'b10;

    localparam logic [1:0] WR = 2'b00, AN = 2'b01, OR_ = 2'b10, RD = 2'b11;
    localparam logic [1:0] CT = 2'b00, RS = 2'b01, IA = 2'b10, IB = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [8:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       irq;
    logic [6:0] ram_base;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    rmw_ctrl_window u0 (
        .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid),
        .acc_addr (acc_addr), .acc_wdata (acc_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .irq (irq), .ram_base (ram_base)
    );

    // One byte access, driven at the falling edge, lasting one cycle.
    task automatic access(input logic [1:0] ar, input logic [1:0] op,
                          input logic [4:0] ix, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = {ar, op, ix};
        acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Read with an expected result queued for the monitor.
    task automatic rd_exp(input logic [1:0] ar, input logic [4:0] ix,
                          input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        access(ar, RD, ix, 8'h00);
    endtask

    // Direct port comparison.
    task automatic chk(input logic [7:0] act, input logic [7:0] e, input string tag);
        vectors++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, e);
        end
    endtask

    // Monitor: compare each returned read with the queue head.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            vectors++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R3: unexpected read %h expected none", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", t, rd_data, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        chk({7'b0, irq}, 8'h00, "R4 reset irq");
        chk({1'b0, ram_base}, 8'h00, "R7 reset base");
        rd_exp(CT, 5'h08, 8'h00, "R4 reset status");
        rd_exp(CT, 5'h01, {4'b0, SZ, 2'b0}, "R6 size field");
        // R1 write, R2 AND/OR on a plain byte
        access(CT, WR, 5'h02, 8'h3C);
        rd_exp(CT, 5'h02, 8'h3C, "R1 write");
        access(CT, AN, 5'h02, 8'hF0);
        rd_exp(CT, 5'h02, 8'h30, "R2 and");
        access(CT, OR_, 5'h02, 8'h05);
        rd_exp(CT, 5'h02, 8'h35, "R2 or");
        access(CT, WR, 5'h18, 8'h81);
        rd_exp(CT, 5'h18, 8'h81, "R1 page byte");
        // R7 relocation byte
        access(CT, WR, 5'h00, 8'hA7);
        rd_exp(CT, 5'h00, 8'hA6, "R7 bit0 zero");
        chk({1'b0, ram_base}, 8'h53, "R7 base bits");
        // R6 read-only size, error with enable off
        access(CT, WR, 5'h01, 8'hFF);
        rd_exp(CT, 5'h01, 8'h08, "R6 unchanged");
        rd_exp(CT, 5'h08, 8'h04, "R6 err pending");
        chk({7'b0, irq}, 8'h00, "R4 gated off");
        access(CT, OR_, 5'h08, 8'h40);
        @(negedge clk);
        chk({7'b0, irq}, 8'h01, "R4 enabled irq");
        access(CT, AN, 5'h08, 8'hFB);
        @(negedge clk);
        chk({7'b0, irq}, 8'h00, "R4 cleared irq");
        rd_exp(CT, 5'h08, 8'h40, "R4 status after clear");
        // R8 identification area A
        for (int i = 0; i < 8; i++) begin
            rd_exp(IA, 5'(i), (i < 6) ? ID_A[8*i +: 8] : 8'h00, "R8 id byte");
        end
        access(IA, WR, 5'h00, 8'h00);
        rd_exp(IA, 5'h00, ID_A[7:0], "R8 unchanged");
        rd_exp(CT, 5'h08, 8'h44, "R8 err pending");
        access(CT, AN, 5'h08, 8'hFB);
        // R9 identification area B
        for (int i = 0; i < 6; i++) begin
            rd_exp(IB, 5'(i), ((i % 2) ? 8'h55 : 8'hAA) ^ 8'(i), "R9 pattern");
        end
        rd_exp(IB, 5'h1F, 8'h55 ^ 8'h1F, "R9 last byte");
        // R10 reserved area and missing index
        rd_exp(RS, 5'h03, 8'h00, "R10 reserved read");
        rd_exp(CT, 5'h08, 8'h44, "R10 reserved err");
        access(CT, AN, 5'h08, 8'hFB);
        rd_exp(CT, 5'h10, 8'h00, "R10 missing index");
        rd_exp(CT, 5'h08, 8'h44, "R10 missing err");
        access(CT, AN, 5'h08, 8'hFB);
        @(negedge clk);
        chk({7'b0, irq}, 8'h00, "R10 cleared");
        // R5 timer: reload 3, period 3*DIV cycles
        access(CT, WR, 5'h0E, 8'h03);
        access(CT, OR_, 5'h0C, 8'h80);
        repeat (5) @(negedge clk);
        chk({7'b0, irq}, 8'h00, "R5 before expiry");
        repeat (10) @(negedge clk);
        chk({7'b0, irq}, 8'h01, "R5 after expiry");
        access(CT, AN, 5'h0C, 8'h7F);
        access(CT, AN, 5'h08, 8'hEF);
        rd_exp(CT, 5'h08, 8'h40, "R5 timer cleared");
        repeat (40) @(negedge clk);
        chk({7'b0, irq}, 8'h00, "R5 stopped no irq");
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule